// File: doc/BRIEF.md
# Auto-ranging period capture timer

This block measures the interval between capture events with one 16-bit counter and a self-adjusting power-of-two prescaler. The counter advances once every 2^ratio count enables. When it fills up, the prescaler slows it down and the count is halved. When a capture finds a small count, the prescaler speeds it up. A single counter can therefore measure slow and fast shafts alike and keep its relative precision.

Two sensor styles are supported. In tachometer mode the count enable is true on every clock cycle, and a rising edge on the tacho input takes a capture. In encoder mode the count enable is an external pulse input. The capture comes from either a manual read strobe or a periodic tick, as chosen by a mode bit.

The block has two sticky status flags, one for a prescaler increase and one for a decrease. A single enable gates both flags onto one interrupt line.

Top module: `period_capture_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the counter, `ratio`, `cap_value`, both flags and `irq` become 0.
- R2: With `sensor_enc`=0, a capture happens in any cycle where `tacho_in` is 1 and was 0 in the previous cycle. `read_strobe` and `rtc_tick` have no effect in this mode.
- R3: With `sensor_enc`=1 and `manual_cap`=1, only `read_strobe` captures. With `manual_cap`=0, only `rtc_tick` captures. `tacho_in` has no effect in encoder mode.
- R4: The count enable is always true in tachometer mode and equals `enc_clk_en` in encoder mode. The counter advances by one on every 2^`ratio`-th count enable. The enable phase restarts after a capture and after any change of `ratio`.
- R5: A capture loads the counter value held before that edge into `cap_value`, and the counter restarts from 0.
- R6: In a cycle with no capture, a counter at all ones with `ratio` below its maximum makes `ratio` rise by one and the counter become all ones shifted right by one bit (0x7FFF by default). `flag_inc` is set.
- R7: A capture that finds the counter below LOW_THRESH (0x5500 by default) with `ratio` above 0 makes `ratio` fall by one and sets `flag_dec`.
- R8: At `ratio` 0, a capture below LOW_THRESH leaves `ratio` at 0 and does not set `flag_dec`.
- R9: At the maximum `ratio` (15 by default), a counter at all ones stays at all ones and `ratio` and both flags stay unchanged. A capture in this state yields all ones in `cap_value`.
- R10: Each flag stays set until a cycle with its clear input high (`clr_inc` or `clr_dec`). A set and a clear in the same cycle leave the flag set.
- R11: `irq` is registered. It is 1 in the cycle after an edge where `irq_en` was 1 and at least one flag holds its new value of 1. Otherwise it is 0.
- R12: When a capture and a full counter meet in the same cycle, only the capture is handled. `ratio` does not rise and `flag_inc` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sensor_enc | input | 1 | Sensor type: 0 tachometer, 1 encoder |
| manual_cap | input | 1 | Encoder capture source: 1 read strobe, 0 periodic tick |
| enc_clk_en | input | 1 | Encoder count enable pulse |
| tacho_in | input | 1 | Tachometer signal, rising edge captures |
| read_strobe | input | 1 | Manual capture strobe |
| rtc_tick | input | 1 | Periodic capture tick |
| irq_en | input | 1 | Shared interrupt enable |
| clr_inc | input | 1 | Clear pulse for flag_inc |
| clr_dec | input | 1 | Clear pulse for flag_dec |
| cap_value | output | CNT_W | Last captured counter value |
| ratio | output | RATIO_W | Current prescaler exponent |
| flag_inc | output | 1 | Sticky flag: prescaler increased |
| flag_dec | output | 1 | Sticky flag: prescaler decreased |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that every input is synchronous to `clk` and that `rst` is asserted for at least one edge before any check matters. They assume nothing about how often capture sources pulse. The stimulus drives all inputs two nanoseconds after the rising edge. It holds reset for several cycles and changes the mode bits only at random intervals, so all three capture sources and the count-enable paths are covered, including mode switches while a count is in progress. Directed parts cover the corner cases that random input rarely reaches: the prescaler ceiling, the floor, and a capture in the same cycle as a full counter.

// File: rtl/pct_pkg.sv
package pct_pkg;
  typedef enum logic [1:0] {
    SRC_TACHO  = 2'd0,
    SRC_MANUAL = 2'd1,
    SRC_TICK   = 2'd2
  } cap_src_e;

  function automatic cap_src_e pick_src(input logic enc, input logic manual);
    if (!enc)       return SRC_TACHO;
    else if (manual) return SRC_MANUAL;
    else            return SRC_TICK;
  endfunction
endpackage

// File: rtl/pct_trigger.sv
module pct_trigger
  import pct_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sensor_enc,
  input  logic manual_cap,
  input  logic enc_clk_en,
  input  logic tacho_in,
  input  logic read_strobe,
  input  logic rtc_tick,
  output logic cap_evt,
  output logic count_en
);
  logic     tacho_prev;
  cap_src_e src;

  always_ff @(posedge clk) begin
    if (rst) tacho_prev <= 1'b0;
    else     tacho_prev <= tacho_in;
  end

  always_comb begin
    src = pick_src(sensor_enc, manual_cap);
    unique case (src)
      SRC_TACHO:  cap_evt = tacho_in & ~tacho_prev;
      SRC_MANUAL: cap_evt = read_strobe;
      SRC_TICK:   cap_evt = rtc_tick;
      default:    cap_evt = 1'b0;
    endcase
    count_en = sensor_enc ? enc_clk_en : 1'b1;
  end
endmodule

// File: rtl/pct_divider.sv
module pct_divider #(
  parameter int RATIO_W = 4,
  parameter int DIV_W   = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               count_en,
  input  logic               clear,
  input  logic [RATIO_W-1:0] ratio,
  output logic               step
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  for (genvar i = 0; i < DIV_W; i++) begin : g_mask
    assign mask[i] = (int'(ratio) > i);
  end

  assign step = count_en && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clear) div_q <= '0;
    else if (count_en) div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pct_range_ctrl.sv
module pct_range_ctrl #(
  parameter int          CNT_W      = 16,
  parameter int          RATIO_W    = 4,
  parameter logic [CNT_W-1:0] LOW_THRESH = 16'h5500
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cap_evt,
  input  logic               step,
  output logic [CNT_W-1:0]   cnt,
  output logic [RATIO_W-1:0] ratio,
  output logic [CNT_W-1:0]   cap_value,
  output logic               set_inc,
  output logic               set_dec,
  output logic               div_clr
);
  localparam logic [CNT_W-1:0]   ALL1 = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0]   HALF = ALL1 >> 1;
  localparam logic [RATIO_W-1:0] RMAX = {RATIO_W{1'b1}};

  logic [CNT_W-1:0]   cnt_n, cap_n;
  logic [RATIO_W-1:0] ratio_n;

  always_comb begin
    cnt_n   = cnt;
    ratio_n = ratio;
    cap_n   = cap_value;
    set_inc = 1'b0;
    set_dec = 1'b0;
    if (cap_evt) begin
      cap_n = cnt;
      cnt_n = '0;
      if (cnt < LOW_THRESH && ratio != '0) begin
        ratio_n = ratio - 1'b1;
        set_dec = 1'b1;
      end
    end else if (cnt == ALL1) begin
      if (ratio != RMAX) begin
        ratio_n = ratio + 1'b1;
        cnt_n   = HALF;
        set_inc = 1'b1;
      end
    end else if (step) begin
      cnt_n = cnt + 1'b1;
    end
    div_clr = cap_evt || (ratio_n != ratio);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      ratio     <= '0;
      cap_value <= '0;
    end else begin
      cnt       <= cnt_n;
      ratio     <= ratio_n;
      cap_value <= cap_n;
    end
  end
endmodule

// File: rtl/pct_status.sv
module pct_status (
  input  logic clk,
  input  logic rst,
  input  logic set_inc,
  input  logic set_dec,
  input  logic clr_inc,
  input  logic clr_dec,
  input  logic irq_en,
  output logic flag_inc,
  output logic flag_dec,
  output logic irq
);
  logic inc_n, dec_n;

  always_comb begin
    inc_n = set_inc | (flag_inc & ~clr_inc);
    dec_n = set_dec | (flag_dec & ~clr_dec);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_inc <= 1'b0;
      flag_dec <= 1'b0;
      irq      <= 1'b0;
    end else begin
      flag_inc <= inc_n;
      flag_dec <= dec_n;
      irq      <= irq_en & (inc_n | dec_n);
    end
  end
endmodule

// File: rtl/period_capture_timer.sv
module period_capture_timer #(
  parameter int               CNT_W      = 16,
  parameter int               RATIO_W    = 4,
  parameter logic [CNT_W-1:0] LOW_THRESH = 16'h5500
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sensor_enc,
  input  logic               manual_cap,
  input  logic               enc_clk_en,
  input  logic               tacho_in,
  input  logic               read_strobe,
  input  logic               rtc_tick,
  input  logic               irq_en,
  input  logic               clr_inc,
  input  logic               clr_dec,
  output logic [CNT_W-1:0]   cap_value,
  output logic [RATIO_W-1:0] ratio,
  output logic               flag_inc,
  output logic               flag_dec,
  output logic               irq
);
  localparam int DIV_W = (1 << RATIO_W) - 1;

  logic             cap_evt, count_en, step, div_clr, set_inc, set_dec;
  logic [CNT_W-1:0] cnt;

  pct_trigger u_trig (
    .clk, .rst, .sensor_enc, .manual_cap, .enc_clk_en,
    .tacho_in, .read_strobe, .rtc_tick,
    .cap_evt(cap_evt), .count_en(count_en)
  );

  pct_divider #(.RATIO_W(RATIO_W), .DIV_W(DIV_W)) u_div (
    .clk, .rst, .count_en(count_en), .clear(div_clr),
    .ratio(ratio), .step(step)
  );

  pct_range_ctrl #(.CNT_W(CNT_W), .RATIO_W(RATIO_W), .LOW_THRESH(LOW_THRESH)) u_rng (
    .clk, .rst, .cap_evt(cap_evt), .step(step),
    .cnt(cnt), .ratio(ratio), .cap_value(cap_value),
    .set_inc(set_inc), .set_dec(set_dec), .div_clr(div_clr)
  );

  pct_status u_stat (
    .clk, .rst, .set_inc(set_inc), .set_dec(set_dec),
    .clr_inc, .clr_dec, .irq_en,
    .flag_inc(flag_inc), .flag_dec(flag_dec), .irq(irq)
  );
endmodule

// File: rtl/pct_checker.sv
module pct_checker #(
  parameter int CNT_W   = 16,
  parameter int RATIO_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               cap_evt,
  input logic [CNT_W-1:0]   cnt,
  input logic [RATIO_W-1:0] ratio,
  input logic               flag_inc,
  input logic               flag_dec,
  input logic               clr_inc,
  input logic               irq_en,
  input logic               irq
);
  localparam logic [CNT_W-1:0]   ALL1 = {CNT_W{1'b1}};
  localparam logic [RATIO_W-1:0] RMAX = {RATIO_W{1'b1}};

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (ratio == '0 && !flag_inc && !flag_dec && !irq));

  a_r5_restart: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> cnt == '0);

  a_r6_single_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (int'(ratio) - int'($past(ratio)) <= 1 && int'($past(ratio)) - int'(ratio) <= 1));

  a_r6_rise_flags: assert property (@(posedge clk) disable iff (rst)
    (int'(ratio) > int'($past(ratio))) |-> flag_inc);

  a_r8_floor: assert property (@(posedge clk) disable iff (rst)
    (ratio == '0 && !flag_dec) |=> !flag_dec);

  a_r9_hold_max: assert property (@(posedge clk) disable iff (rst)
    (ratio == RMAX && cnt == ALL1 && !cap_evt) |=> (cnt == ALL1 && ratio == RMAX));

  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_inc && !clr_inc) |=> flag_inc);

  a_r11_gate: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);
endmodule

bind period_capture_timer pct_checker #(.CNT_W(CNT_W), .RATIO_W(RATIO_W)) u_chk (
  .clk(clk), .rst(rst), .cap_evt(cap_evt), .cnt(cnt), .ratio(ratio),
  .flag_inc(flag_inc), .flag_dec(flag_dec), .clr_inc(clr_inc),
  .irq_en(irq_en), .irq(irq)
);

// File: tb/sim_period_capture_timer.sv
`timescale 1ns/1ps
module sim_period_capture_timer;
  localparam int         CW  = 8;
  localparam int         RW  = 2;
  localparam logic [7:0] TH  = 8'h55;
  localparam logic [7:0] F   = 8'hFF;
  localparam logic [1:0] RMX = 2'd3;

  logic clk = 1'b0;
  logic rst, sensor_enc, manual_cap, enc_clk_en, tacho_in, read_strobe, rtc_tick;
  logic irq_en, clr_inc, clr_dec;
  logic [CW-1:0] cap_value;
  logic [RW-1:0] ratio;
  logic flag_inc, flag_dec, irq;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // reference state
  logic [CW-1:0] m_cnt, m_cap;
  logic [RW-1:0] m_ratio;
  logic [2:0]    m_div;
  logic          m_fi, m_fd, m_irq, m_tp;

  always #10 clk = ~clk;

  period_capture_timer #(.CNT_W(CW), .RATIO_W(RW), .LOW_THRESH(TH)) u0 (
    .clk, .rst, .sensor_enc, .manual_cap, .enc_clk_en, .tacho_in,
    .read_strobe, .rtc_tick, .irq_en, .clr_inc, .clr_dec,
    .cap_value, .ratio, .flag_inc, .flag_dec, .irq
  );

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", t, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] mask_of(input logic [RW-1:0] r);
    return 3'((1 << r) - 1);
  endfunction

  task automatic model_step();
    logic cap, cen, stp, si, sd;
    logic [RW-1:0] r_old;
    r_old = m_ratio;
    si = 1'b0; sd = 1'b0;
    if (rst) begin
      m_cnt = '0; m_cap = '0; m_ratio = '0; m_div = '0;
      m_fi = 1'b0; m_fd = 1'b0; m_irq = 1'b0; m_tp = 1'b0;
      return;
    end
    cap = !sensor_enc ? (tacho_in && !m_tp) : (manual_cap ? read_strobe : rtc_tick);
    cen = sensor_enc ? enc_clk_en : 1'b1;
    stp = cen && ((m_div & mask_of(m_ratio)) == mask_of(m_ratio));
    if (cap) begin
      if (m_cnt < TH && m_ratio != 0) begin m_ratio--; sd = 1'b1; end
      m_cap = m_cnt; m_cnt = '0;
    end else if (m_cnt == F) begin
      if (m_ratio != RMX) begin m_ratio++; m_cnt = F >> 1; si = 1'b1; end
    end else if (stp) m_cnt++;
    if (cap || m_ratio != r_old) m_div = '0;
    else if (cen) m_div++;
    m_fi = si | (m_fi & ~clr_inc);
    m_fd = sd | (m_fd & ~clr_dec);
    m_irq = irq_en & (m_fi | m_fd);
    m_tp = tacho_in;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk); #2;
    chk({tag, " cap_value"}, 32'(cap_value), 32'(m_cap));
    chk({tag, " ratio"},     32'(ratio),     32'(m_ratio));
    chk({tag, " flag_inc"},  32'(flag_inc),  32'(m_fi));
    chk({tag, " flag_dec"},  32'(flag_dec),  32'(m_fd));
    chk({tag, " irq"},       32'(irq),       32'(m_irq));
    {read_strobe, rtc_tick, clr_inc, clr_dec} = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic do_reset();
    rst = 1'b1; idle(4); rst = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] keep;
    {sensor_enc, manual_cap, enc_clk_en, tacho_in, read_strobe, rtc_tick} = '0;
    {irq_en, clr_inc, clr_dec} = '0;
    tag = "R1"; do_reset();
    chk("R1 ratio", 32'(ratio), 0); chk("R1 cap", 32'(cap_value), 0);
    chk("R1 flags", 32'({flag_inc, flag_dec, irq}), 0);

    // R12: capture exactly when the counter is full
    tag = "R12";
    while (m_cnt != F) cyc();
    tacho_in = 1'b1; cyc(); tacho_in = 1'b0;
    chk("R12 cap", 32'(cap_value), 32'hFF); chk("R12 ratio", 32'(ratio), 0);
    chk("R12 flag_inc", 32'(flag_inc), 0);

    // R5 / R8: restart from zero, floor at ratio 0
    tag = "R5"; idle(19);
    tacho_in = 1'b1; cyc(); tacho_in = 1'b0;
    chk("R5 cap", 32'(cap_value), 19);
    chk("R8 ratio", 32'(ratio), 0); chk("R8 flag_dec", 32'(flag_dec), 0);

    // R6 / R11: overflow raises the ratio
    tag = "R6"; irq_en = 1'b1; idle(260);
    chk("R6 ratio", 32'(ratio), 1); chk("R6 flag_inc", 32'(flag_inc), 1);
    chk("R11 irq", 32'(irq), 1);

    // R10: clear pulse
    tag = "R10"; clr_inc = 1'b1; cyc();
    chk("R10 flag_inc", 32'(flag_inc), 0); chk("R11 irq low", 32'(irq), 0);

    // R9: ceiling
    tag = "R9"; idle(3000);
    chk("R9 ratio", 32'(ratio), 3);
    tacho_in = 1'b1; cyc(); tacho_in = 1'b0;
    chk("R9 cap", 32'(cap_value), 32'hFF); chk("R9 ratio kept", 32'(ratio), 3);

    // R7: small capture lowers the ratio
    tag = "R7"; idle(10);
    tacho_in = 1'b1; cyc(); tacho_in = 1'b0;
    chk("R7 ratio", 32'(ratio), 2); chk("R7 flag_dec", 32'(flag_dec), 1);

    // R3: encoder manual mode ignores tick and tacho
    tag = "R3"; sensor_enc = 1'b1; manual_cap = 1'b1; enc_clk_en = 1'b1;
    keep = cap_value; idle(5);
    rtc_tick = 1'b1; cyc(); idle(2); tacho_in = 1'b1; cyc(); tacho_in = 1'b0; cyc();
    chk("R3 ignored", 32'(cap_value), 32'(keep));
    read_strobe = 1'b1; cyc();
    manual_cap = 1'b0; keep = cap_value; idle(3);
    read_strobe = 1'b1; cyc();
    chk("R3 strobe ignored", 32'(cap_value), 32'(keep));
    rtc_tick = 1'b1; cyc();

    // R4: count rate with a gappy encoder enable
    tag = "R4";
    for (int i = 0; i < 120; i++) begin enc_clk_en = (i % 3) != 0; cyc(); end
    rtc_tick = 1'b1; cyc();

    // R2: tacho mode ignores strobe and tick
    tag = "R2"; sensor_enc = 1'b0; keep = cap_value;
    read_strobe = 1'b1; cyc(); rtc_tick = 1'b1; cyc();
    chk("R2 ignored", 32'(cap_value), 32'(keep));

    // random mix
    tag = "R4 random"; void'($urandom(32'd4242)); do_reset();
    for (int i = 0; i < 40000; i++) begin
      if ($urandom_range(0, 499) == 0) sensor_enc = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 499) == 0) manual_cap = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 199) == 0) irq_en = ~irq_en;
      enc_clk_en  = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 149) == 0) tacho_in = ~tacho_in;
      read_strobe = $urandom_range(0, 299) == 0;
      rtc_tick    = $urandom_range(0, 299) == 0;
      clr_inc     = $urandom_range(0, 99) == 0;
      clr_dec     = $urandom_range(0, 99) == 0;
      model_step();
      @(posedge clk); #2;
      chk("R2/R3 random cap", 32'(cap_value), 32'(m_cap));
      chk("R6/R7 random ratio", 32'(ratio), 32'(m_ratio));
      chk("R10 random flags", 32'({flag_inc, flag_dec}), 32'({m_fi, m_fd}));
      chk("R11 random irq", 32'(irq), 32'(m_irq));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule